// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one timer channel built from two stages. A prescaler divides the system clock into a slower tick. Its period is `PRESCALE*256 + 64` system clocks, where PRESCALE is an 8-bit value. A 16-bit down counter then consumes those ticks. The counter expires once every `COUNT + 1` ticks and raises an interrupt request flag when it does.

A register bank outside this block drives the control inputs. The enable and auto-restart bits arrive as levels. A new period arrives as a 16-bit value with a one-cycle load strobe, and the bank has already assembled it from bytes. The interrupt flag is cleared with a one-cycle pulse. In one-shot mode the timer stops itself on expiry. It signals this with a one-cycle pulse so that the bank can clear its stored enable bit. In auto-restart mode the counter reloads the stored period and keeps running.

A load takes effect on the next clock whether the channel is enabled or not. Loading a new value, or enabling a disabled channel, restarts the prescaler, so the first tick after either event comes a full prescaler period later.

Top module: `prescaled_timer`

## Requirements
- R1: The prescaler ticks once every `prescale_i*256 + 64` clock cycles while the channel runs. The count stays unchanged until the first tick, and each tick lowers it by one.
- R2: After a load of value N at clock edge L, with the channel enabled throughout, `irq_o` is 0 after edge `L + (N+1)*P - 1` and 1 after edge `L + (N+1)*P`. Here P is the prescaler period.
- R3: While `en_i` is 0 and no load is applied, `count_o` holds and `irq_o` is not set.
- R4: With `auto_i` = 1, the count returns to the last loaded value at the expiry edge, and `en_stop_o` stays 0.
- R5: With `auto_i` = 0, the count stays 0 at expiry and `en_stop_o` is 1 for exactly the one cycle after the expiry edge.
- R6: A `load_i` pulse makes `count_o` equal to `reload_i` after the next clock edge, whether the channel is enabled or not. An enabled channel then continues counting down from that value.
- R7: When `en_i` rises at edge E, the first decrement happens at edge E + P.
- R8: Once set, `irq_o` stays 1 until `irq_clr_i` is sampled high at a clock edge with no expiry. After that edge it reads 0.
- R9: An expiry and a clear pulse at the same edge leave `irq_o` at 1.
- R10: While reset is active, `count_o` reads 0 and both `irq_o` and `en_stop_o` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable level from the control register |
| auto_i | input | 1 | 1 = reload and continue on expiry, 0 = stop on expiry |
| prescale_i | input | 8 | Prescaler coarse divide value |
| reload_i | input | 16 | Period value to be loaded |
| load_i | input | 1 | One-cycle strobe that loads `reload_i` |
| irq_clr_i | input | 1 | One-cycle pulse that clears the interrupt flag |
| count_o | output | 16 | Live counter value |
| irq_o | output | 1 | Interrupt request flag |
| en_stop_o | output | 1 | One-cycle pulse: the one-shot expiry has stopped the channel |

## Verification
Every result is a registered output. A load shows up in `count_o` after the very next edge. A decrement lands P edges after a load or an enable rise, and an expiry lands `(N+1)*P` edges after the load, where the same edge also sets `irq_o` and starts the `en_stop_o` pulse. A clear shows up one edge after it is sampled. The bench drives inputs one nanosecond after a rising edge and counts edges from the load or enable edge with a single wait helper. It samples each output both one edge before and exactly at the edge where it is due, so an off-by-one in either the prescaler or the counter is caught.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   // Action chosen by the down counter in a cycle
   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_LOAD,
      ACT_DEC,
      ACT_RELOAD,
      ACT_STOP
   } cnt_act_e;

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int PRE_W    = 8,
   parameter int FINE_W   = 8,
   parameter int BASE_DIV = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [PRE_W-1:0] prescale_i,
   output logic             tick_o
);

   localparam int LIM_W = PRE_W + FINE_W + 1;

   if (PRE_W < 1 || FINE_W < 1) begin : g_bad_width
      $error("ptmr_prescaler: PRE_W and FINE_W must be at least 1");
   end
   if (BASE_DIV < 2 || BASE_DIV > (2 ** FINE_W)) begin : g_bad_base
      $error("ptmr_prescaler: BASE_DIV must lie in 2 .. 2**FINE_W");
   end

   logic [LIM_W-1:0] limit;
   logic [LIM_W-1:0] pcnt;

   // Last count value of one period: prescale*2^FINE_W + BASE_DIV - 1
   assign limit  = {1'b0, prescale_i, {FINE_W{1'b0}}} + LIM_W'(BASE_DIV - 1);
   assign tick_o = run_i && !restart_i && (pcnt >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)         pcnt <= '0;
      else if (restart_i) pcnt <= '0;
      else if (run_i)     pcnt <= tick_o ? '0 : pcnt + 1'b1;
   end

   // Ticks are at least two cycles apart
   assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

   // No tick is ever produced while stopped
   assert_no_tick_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> !tick_o);

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             auto_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ptmr_counter: CNT_W must be at least 2");
   end

   cnt_act_e         act;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] reload_q;

   always_comb begin
      if (load_i)                        act = ACT_LOAD;
      else if (tick_i && count_q == '0)  act = auto_i ? ACT_RELOAD : ACT_STOP;
      else if (tick_i)                   act = ACT_DEC;
      else                               act = ACT_HOLD;
   end

   assign expire_o = (act == ACT_RELOAD) || (act == ACT_STOP);
   assign count_o  = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
      end else begin
         if (act == ACT_LOAD) reload_q <= reload_i;
         unique case (act)
            ACT_LOAD:   count_q <= reload_i;
            ACT_DEC:    count_q <= count_q - 1'b1;
            ACT_RELOAD: count_q <= reload_q;
            default:    count_q <= count_q;
         endcase
      end
   end

   // Auto mode returns to the stored period on expiry
   assert_auto_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && auto_i) |=> count_q == $past(reload_q));

   // A tick without load and without expiry lowers the count by one
   assert_dec_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && !expire_o) |=> count_q == $past(count_q) - 1'b1);

endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);

   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     irq_q <= 1'b0;
      else if (set_i) irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irq_q);

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !irq_q);

   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_i) |=> irq_q);

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
   parameter int PRE_W    = 8,
   parameter int FINE_W   = 8,
   parameter int BASE_DIV = 64,
   parameter int CNT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             auto_i,
   input  logic [PRE_W-1:0] prescale_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             load_i,
   input  logic             irq_clr_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic             en_stop_o
);

   logic en_q;
   logic restart;
   logic tick;
   logic expire;
   logic stop_q;

   // Prescaler starts a fresh period on load or on an enable rise
   assign restart = load_i || (en_i && !en_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         stop_q <= 1'b0;
      end else begin
         en_q   <= en_i;
         stop_q <= expire && !auto_i;
      end
   end

   assign en_stop_o = stop_q;

   ptmr_prescaler #(
      .PRE_W    (PRE_W),
      .FINE_W   (FINE_W),
      .BASE_DIV (BASE_DIV)
   ) u_pre (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (en_i),
      .restart_i  (restart),
      .prescale_i (prescale_i),
      .tick_o     (tick)
   );

   ptmr_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick),
      .load_i   (load_i),
      .reload_i (reload_i),
      .auto_i   (auto_i),
      .count_o  (count_o),
      .expire_o (expire)
   );

   ptmr_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (expire),
      .clr_i (irq_clr_i),
      .irq_o (irq_o)
   );

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !load_i) |=> $stable(count_o));

   assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> count_o == $past(reload_i));

   assert_stop_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en_stop_o |-> (irq_o && count_o == '0));

   assert_stop_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      en_stop_o |=> !en_stop_o);

   assert_auto_no_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && auto_i) |=> !en_stop_o);

endmodule

// File: tb/prescaled_timer_bench.sv
`timescale 1ns/1ps
module prescaled_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic        auto_i = 1'b0;
   logic [7:0]  prescale_i = '0;
   logic [15:0] reload_i = '0;
   logic        load_i = 1'b0;
   logic        irq_clr_i = 1'b0;
   logic [15:0] count_o;
   logic        irq_o;
   logic        en_stop_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   prescaled_timer u_prescaled_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .auto_i     (auto_i),
      .prescale_i (prescale_i),
      .reload_i   (reload_i),
      .load_i     (load_i),
      .irq_clr_i  (irq_clr_i),
      .count_o    (count_o),
      .irq_o      (irq_o),
      .en_stop_o  (en_stop_o)
   );

   // {prescale[24:17], reload[16:1], auto[0]}
   localparam logic [24:0] VECS [0:3] = '{
      {8'd0, 16'd0, 1'b1},
      {8'd0, 16'd3, 1'b1},
      {8'd1, 16'd2, 1'b1},
      {8'd2, 16'd1, 1'b1}
   };

   function automatic int period(input int ps);
      return ps * 256 + 64;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Advance n rising edges, then land 1 ns after the last one
   task automatic wait_n(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_load(input int val);
      reload_i = 16'(val);
      load_i = 1'b1;
      wait_n(1);
      load_i = 1'b0;
   endtask

   task automatic clr_pulse();
      irq_clr_i = 1'b1;
      wait_n(1);
      irq_clr_i = 1'b0;
   endtask

   initial begin
      wait_n(3);
      // R10 reset state
      check("R10 count in reset", int'(count_o), 0);
      check("R10 irq in reset", int'(irq_o), 0);
      check("R10 stop pulse in reset", int'(en_stop_o), 0);
      rst_n = 1'b1;
      wait_n(1);

      // Vector table: enabled auto-restart runs
      en_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
         int ps;
         int rv;
         int p;
         ps = int'(VECS[i][24:17]);
         rv = int'(VECS[i][16:1]);
         p  = period(ps);
         prescale_i = VECS[i][24:17];
         auto_i     = VECS[i][0];
         clr_pulse();
         do_load(rv);                            // now just after edge L
         check("R6 count after load", int'(count_o), rv);
         wait_n(p - 1);
         check("R1 count before first tick", int'(count_o), rv);
         check("R2 irq before expiry", int'(irq_o), 0);
         if (rv != 0) begin
            wait_n(1);
            check("R1 count after first tick", int'(count_o), rv - 1);
            wait_n(rv * p - 1);
            check("R2 irq one edge before expiry", int'(irq_o), 0);
         end
         wait_n(1);
         check("R2 irq at expiry", int'(irq_o), 1);
         check("R4 count reloaded", int'(count_o), rv);
         check("R4 no stop pulse in auto", int'(en_stop_o), 0);
      end

      // R3 and R6: load while disabled, then hold
      en_i = 1'b0;
      prescale_i = 8'd0;
      clr_pulse();
      do_load(5);
      check("R6 load while disabled", int'(count_o), 5);
      wait_n(1000);
      check("R3 count holds while disabled", int'(count_o), 5);
      check("R3 no irq while disabled", int'(irq_o), 0);

      // R7: enable rise restarts prescaler
      en_i = 1'b1;
      wait_n(1);                                 // just after edge E
      wait_n(63);
      check("R7 no decrement before E+P", int'(count_o), 5);
      wait_n(1);
      check("R7 decrement at E+P", int'(count_o), 4);

      // R6: reload while running
      auto_i = 1'b1;
      wait_n(32);
      do_load(3);                                // edge L2
      check("R6 reload while running", int'(count_o), 3);
      wait_n(64);
      check("R6 continue from new value", int'(count_o), 2);
      wait_n(64 * 3 - 1);
      check("R2 irq before expiry after reload", int'(irq_o), 0);
      wait_n(1);                                 // L2+256
      check("R2 irq after reload expiry", int'(irq_o), 1);

      // R9 then R8: clear pulse held across next expiry edge (L2+512)
      wait_n(255);                               // L2+511
      irq_clr_i = 1'b1;
      wait_n(1);                                 // L2+512, expiry edge
      check("R9 set wins over clear", int'(irq_o), 1);
      wait_n(1);
      check("R8 clear takes effect", int'(irq_o), 0);
      irq_clr_i = 1'b0;
      wait_n(10);
      check("R8 stays clear", int'(irq_o), 0);

      // R5: one-shot
      auto_i = 1'b0;
      do_load(1);                                // edge L3, expiry at L3+128
      wait_n(127);
      check("R5 no stop pulse before expiry", int'(en_stop_o), 0);
      wait_n(1);
      check("R5 stop pulse at expiry", int'(en_stop_o), 1);
      check("R5 count zero at expiry", int'(count_o), 0);
      check("R2 irq one-shot expiry", int'(irq_o), 1);
      en_i = 1'b0;
      wait_n(1);
      check("R5 stop pulse lasts one cycle", int'(en_stop_o), 0);
      wait_n(300);
      check("R5 count stays zero", int'(count_o), 0);
      check("R8 irq stays set without clear", int'(irq_o), 1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule